// File: doc/BRIEF.md
# Limit-Compare Periodic Counter Timer

A word-addressed counter/timer for a large chip's peripheral space. Each cycle in which the tick-enable input is high, an internal count advances by one unit. The unit sits at bit 9 of the register view, so the count reads as a multiple of 0x200 and its nine low bits are always zero. With the default tick source each unit is 500 ns. Software programs a limit. On the tick that would carry the count up to the limit, the count reloads to zero instead. That same tick sets a sticky reached flag and raises a level interrupt, so the block acts as a periodic timer whose period is the limit's unit field in ticks.

A limit of zero selects free-run. The count then sweeps the whole CNT_W-bit field and wraps silently, with no reached flag and no interrupt. A second limit address changes the limit without restarting the count. Reading the limit acknowledges the event. Control sits in a two-state mode machine: ST_FREE (limit is zero) and ST_PERIODIC (limit is nonzero). Any limit write takes the transition ST_FREE to ST_PERIODIC when the written value is nonzero, or ST_PERIODIC to ST_FREE when it is zero. Otherwise the machine holds its state. Reset enters ST_FREE.

Top module: `lcpt_timer`

## Requirements
- R1: After reset the limit reads 0, the counter reads 0, the interrupt is low and the count runs in free-run.
- R2: Each cycle with tick_en high advances the count field (bits CNT_W-1..9 of the counter word) by one, that is by 0x200. With tick_en low the count holds. Bits 8..0 of the counter word always read zero.
- R3: With a nonzero limit, a tick whose incremented count field equals the limit's bits CNT_W-1..9 loads the count with zero, sets the reached flag and raises irq. The count therefore repeats with a period of limit>>9 ticks.
- R4: With a limit of all zeros the count wraps from its largest value to zero, and neither the reached flag nor irq is ever set.
- R5: irq is a level that stays high until acknowledged. The reached flag stays set across later matches until a limit read, and irq is never high while the reached flag is clear.
- R6: A read at byte offset 0x0 returns the limit zero-extended to 32 bits and clears both the reached flag and irq. A match in the same cycle takes precedence.
- R7: A write at offset 0x0 stores wdata masked to CNT_W bits, loads the count with zero (overriding a tick in the same cycle) and drops irq. It leaves the reached flag as it was.
- R8: A write at offset 0x8 stores the masked limit and leaves the count running. If the new limit lies at or below the count, the count runs on to the full-range wrap before it can match.
- R9: Writes at offsets 0x4, 0xC and 0x10 change nothing. Reads at 0x8, 0xC and 0x10 return zero.
- R10: A read at offset 0x4 returns the reached flag in bit 31 and the count in bits CNT_W-1..9, with all other bits zero. This read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One count unit per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | ADDR_W | Byte address, bits 1..0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every nonzero limit of a small configuration (five count bits) across more than two periods. An off-by-one compare would show up as a wrong period, or as a count that passes the limit instead of reloading. Free-run is driven past the full-range wrap, where a design that treats zero as a match value would raise irq. A limit reload below the current count must run to the wrap: a magnitude compare would fire early, and a design that restarts the count would read zero. Acknowledge rules are probed at the ports. A limit write must drop irq but keep bit 31, and writes to the counter address must leave the count unchanged.

// File: rtl/lcpt_pkg.sv
`timescale 1ns/1ps
package lcpt_pkg;

    typedef enum logic [0:0] {
        ST_FREE     = 1'b0,
        ST_PERIODIC = 1'b1
    } lcpt_mode_e;

    // word index = byte address >> 2
    typedef enum logic [2:0] {
        REG_LIMIT    = 3'd0,
        REG_COUNT    = 3'd1,
        REG_LIMIT_NR = 3'd2,
        REG_STAT     = 3'd3,
        REG_MODE     = 3'd4
    } lcpt_reg_e;

    typedef struct packed {
        logic wr_lim;
        logic wr_lim_nr;
        logic rd_lim;
    } lcpt_cmd_t;

endpackage

// File: rtl/lcpt_decode.sv
`timescale 1ns/1ps
module lcpt_decode
    import lcpt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output lcpt_cmd_t         cmd,
    output lcpt_reg_e         rsel,
    output logic              rhit
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int NUM_REGS = 5;

    logic [WORD_W-1:0] word;

    always_comb begin
        word = addr[ADDR_W-1:2];
        rhit = (int'(word) < NUM_REGS);
        rsel = lcpt_reg_e'(word[2:0]);
        cmd.wr_lim    = wr_en && rhit && (rsel == REG_LIMIT);
        cmd.wr_lim_nr = wr_en && rhit && (rsel == REG_LIMIT_NR);
        cmd.rd_lim    = rd_en && rhit && (rsel == REG_LIMIT);
    end

    always_comb begin
        assert (!(cmd.wr_lim && cmd.wr_lim_nr)) else $error("AST_ONE_LIMIT_PATH"); // R8
    end
endmodule

// File: rtl/lcpt_mode_fsm.sv
`timescale 1ns/1ps
module lcpt_mode_fsm
    import lcpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       load_zero,
    output lcpt_mode_e state,
    output logic       periodic
);
    lcpt_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:     if (load && !load_zero) state_d = ST_PERIODIC;
            ST_PERIODIC: if (load && load_zero)  state_d = ST_FREE;
            default:     state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state    = state_q;
        periodic = (state_q == ST_PERIODIC);
    end

    AST_ZERO_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        load && load_zero |=> !periodic); // R4
endmodule

// File: rtl/lcpt_counter.sv
`timescale 1ns/1ps
module lcpt_counter #(
    parameter int UNIT_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    input  logic              periodic,
    input  logic [UNIT_W-1:0] lim_units,
    output logic [UNIT_W-1:0] cnt_units,
    output logic              match
);
    logic [UNIT_W-1:0] cnt_q, cnt_inc;

    always_comb begin
        cnt_inc   = cnt_q + 1'b1;
        match     = tick && !clr && periodic && (cnt_inc == lim_units);
        cnt_units = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (match) cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_inc;
    end

    AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !clr && !match |=> cnt_units == $past(cnt_units) + 1'b1); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !clr |=> $stable(cnt_units)); // R2
    AST_MATCH_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cnt_units == '0); // R3
endmodule

// File: rtl/lcpt_flags.sv
`timescale 1ns/1ps
module lcpt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack_rd,
    input  logic ack_wr,
    output logic reached,
    output logic irq
);
    logic reached_q, irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (hit)         reached_q <= 1'b1;
            else if (ack_rd) reached_q <= 1'b0;

            if (hit)                  irq_q <= 1'b1;
            else if (ack_rd || ack_wr) irq_q <= 1'b0;
        end
    end

    always_comb begin
        reached = reached_q;
        irq     = irq_q;
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reached); // R5
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack_rd && !ack_wr |=> irq); // R5
    AST_HIT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq && reached); // R3
    AST_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd && !hit |=> !irq && !reached); // R6
endmodule

// File: rtl/lcpt_timer.sv
`timescale 1ns/1ps
module lcpt_timer
    import lcpt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 31,
    parameter int SUB_W  = 9,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int UNIT_W = CNT_W - SUB_W;

    lcpt_cmd_t         cmd;
    lcpt_reg_e         rsel;
    logic              rhit;
    lcpt_mode_e        mode;
    logic              periodic;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  wlim;
    logic              lim_load;
    logic [UNIT_W-1:0] cnt_units;
    logic              match;
    logic              reached;
    logic [DATA_W-1:0] lim_word, cnt_word;

    lcpt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .cmd   (cmd),
        .rsel  (rsel),
        .rhit  (rhit)
    );

    always_comb begin
        wlim     = wdata[CNT_W-1:0];
        lim_load = cmd.wr_lim || cmd.wr_lim_nr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= '0;
        else if (lim_load) limit_q <= wlim;
    end

    lcpt_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (lim_load),
        .load_zero (wlim == '0),
        .state     (mode),
        .periodic  (periodic)
    );

    lcpt_counter #(.UNIT_W(UNIT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .clr       (cmd.wr_lim),
        .periodic  (periodic),
        .lim_units (limit_q[CNT_W-1:SUB_W]),
        .cnt_units (cnt_units),
        .match     (match)
    );

    lcpt_flags u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (match),
        .ack_rd  (cmd.rd_lim),
        .ack_wr  (cmd.wr_lim),
        .reached (reached),
        .irq     (irq)
    );

    always_comb begin
        lim_word = '0;
        lim_word[CNT_W-1:0] = limit_q;
        cnt_word = '0;
        cnt_word[CNT_W-1:SUB_W] = cnt_units;
        cnt_word[DATA_W-1] = reached;
        rdata = '0;
        if (rhit) begin
            unique case (rsel)
                REG_LIMIT: rdata = lim_word;
                REG_COUNT: rdata = cnt_word;
                default:   rdata = '0;
            endcase
        end
    end

    AST_MODE_TRACKS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_PERIODIC) == (limit_q != '0)); // R4
    AST_FREE_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_FREE) |-> !match); // R4
    AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.wr_lim |=> cnt_units == '0 && !irq); // R7
    AST_NR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.wr_lim_nr && !tick_en |=> $stable(cnt_units)); // R8
endmodule

// File: tb/tb_lcpt_timer.sv
`timescale 1ns/1ps
module tb_lcpt_timer;
    localparam int CNT_W = 14;
    localparam int SUB_W = 9;
    localparam int UNITS = 1 << (CNT_W - SUB_W);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0;
    int m_lim = 0;
    int m_reached = 0;
    int m_irq = 0;

    always #2 clk = ~clk;

    lcpt_timer #(.CNT_W(CNT_W), .SUB_W(SUB_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_cnt_word();
        return (m_reached != 0 ? 32'h8000_0000 : 32'h0) | (m_cnt << SUB_W);
    endfunction

    function automatic void model_tick();
        int lu = m_lim >> SUB_W;
        int nx = (m_cnt + 1) % UNITS;
        if (m_lim != 0 && nx == lu) begin
            m_cnt = 0; m_reached = 1; m_irq = 1;
        end else begin
            m_cnt = nx;
        end
    endfunction

    task automatic idle();
        @(negedge clk);
        tick_en = 0; wr_en = 0; rd_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1; wr_en = 0; rd_en = 0;
            @(posedge clk);
            model_tick();
        end
        idle();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_en = 0; wr_en = 1; rd_en = 0; addr = a; wdata = d;
        @(posedge clk);
        if (a == 5'h00) begin
            m_lim = d & ((1 << CNT_W) - 1); m_cnt = 0; m_irq = 0;
        end else if (a == 5'h08) begin
            m_lim = d & ((1 << CNT_W) - 1);
        end
        idle();
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        tick_en = 0; wr_en = 0; rd_en = 1; addr = a;
        #1 d = rdata;
        @(posedge clk);
        if (a == 5'h00) begin
            m_reached = 0; m_irq = 0;
        end
        idle();
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        rd(5'h04, v);
        chk(req, v, exp_cnt_word());
        chk(req, {31'd0, irq}, m_irq[31:0]);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();

        // R1 reset state
        rd(5'h00, v); chk("R1 limit", v, 32'h0);
        check_state("R1 count/irq");

        // R4 free-run through the full wrap, R2 steps of 0x200
        for (int k = 0; k < UNITS + 3; k++) begin
            ticks(1);
            check_state("R4 R2 free-run");
        end

        // R2 no tick, no change
        repeat (5) idle();
        check_state("R2 hold");

        // R3 R5 R6 sweep of every nonzero limit
        for (int L = 1; L < UNITS; L++) begin
            wr(5'h00, L << SUB_W);
            check_state("R7 restart");
            for (int k = 0; k < 2 * L + 1; k++) begin
                ticks(1);
                check_state("R3 R5 periodic");
            end
            if (L == 7) begin
                // R7 limit write drops irq, keeps reached
                wr(5'h00, L << SUB_W);
                check_state("R7 keeps reached");
                ticks(L);
                check_state("R5 re-raise");
            end
            rd(5'h00, v); chk("R6 limit readback", v, L << SUB_W);
            check_state("R6 ack");
        end

        // R7 masking to CNT_W bits
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, v); chk("R7 mask", v, (1 << CNT_W) - 1);
        ticks(UNITS);
        check_state("R3 masked limit");
        rd(5'h00, v);

        // R8 raise limit without restart
        wr(5'h00, 10 << SUB_W);
        ticks(4);
        wr(5'h08, 20 << SUB_W);
        check_state("R8 count kept");
        ticks(15);
        check_state("R8 before match");
        ticks(1);
        check_state("R8 match at new limit");
        rd(5'h00, v);

        // R8 lower limit below count: runs to wrap
        ticks(8);
        wr(5'h08, 5 << SUB_W);
        check_state("R8 lowered");
        for (int k = 0; k < UNITS; k++) begin
            ticks(1);
            check_state("R8 run to wrap");
        end
        rd(5'h00, v);

        // R9 ignored writes and zero reads
        ticks(2);
        wr(5'h04, 32'h0000_1E00);
        check_state("R9 counter write ignored");
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        check_state("R9 status/mode write ignored");
        rd(5'h00, v); chk("R9 limit unchanged", v, 5 << SUB_W);
        rd(5'h08, v); chk("R9 read 0x8", v, 32'h0);
        rd(5'h0C, v); chk("R9 read 0xC", v, 32'h0);
        rd(5'h10, v); chk("R9 read 0x10", v, 32'h0);

        // R10 counter read has no side effect
        ticks(10);
        check_state("R10 reached visible");
        check_state("R10 reread unchanged");

        // R4 back to free-run via limit write of zero
        wr(5'h00, 32'h0);
        rd(5'h00, v);
        for (int k = 0; k < UNITS + 2; k++) ticks(1);
        check_state("R4 zero limit no match");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule